// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block gathers 32 asynchronous interrupt source lines into one request towards a processor core. Each line passes through a two-stage synchronizer and then feeds a per-line pending bit in a status register. A mask register, one enable bit per line, gates which pending bits may raise the core request. A small register port reads and writes both registers, and the block also reports the number of the lowest-numbered pending line.

A compile-time parameter fixes how the pending bits behave. In live-level mode a pending bit follows the synchronized input and writes to status do nothing. In edge mode a rising edge sets the bit, and the bit holds until software writes a one to that position. In latched-level mode a high input sets the bit, and the bit holds until software writes a zero to that position. This last mode lets software clear one line by writing the inverse of that line's single-bit pattern. When an event and a clearing write land on the same bit in the same cycle, the event wins.

Top module: `irq_hub`

## Requirements
- R1: Source line i (i from 0 to 31) maps to bit i of the status register and of the mask register, and to index value i on the pending-index output.
- R2: The mask register resets to all zeros. A write with regSel=1, regWr=1 and regAddr=0 replaces the whole mask at the next clock edge. Read data is combinational: it shows the mask when regAddr=0, the status when regAddr=1, and zero when regSel=0.
- R3: The status register resets to all zeros and is read with regAddr=1.
- R4: A change on a source input reaches the live-level status two clock edges after it is sampled. It reaches a latched status bit three edges after it is sampled.
- R5: In edge mode (MODE=IRQ_EDGE_W1C) a rising edge of the synchronized input sets the status bit. Writing 1 to a status bit clears it, and writing 0 has no effect. A line held high does not set its bit again after a clear.
- R6: In latched-level mode (MODE=IRQ_LEVEL_W0C) a high synchronized input sets the status bit. Writing 0 to a status bit clears it, and writing 1 has no effect. A bit stays set after its input falls.
- R7: In live-level mode (MODE=IRQ_LIVE_LEVEL) status equals the synchronized inputs, and writes to status have no effect.
- R8: If a setting event and a clearing write reach the same status bit in the same cycle, the bit ends up set.
- R9: cpuIrq is high exactly when some bit is set in both status and mask.
- R10: pendIdx gives the index of the least significant set status bit, whether or not that bit is masked, and pendValid is high whenever status is non-zero. When status is zero, pendValid is low and pendIdx is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcIn | input | 32 | Asynchronous interrupt source lines |
| regSel | input | 1 | Register port select |
| regWr | input | 1 | Write enable, qualified by regSel |
| regAddr | input | 1 | 0 selects mask, 1 selects status |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Combinational read data |
| cpuIrq | output | 1 | Interrupt request to the core |
| pendIdx | output | 5 | Index of the lowest pending line |
| pendValid | output | 1 | High when any status bit is set |

## Verification
The assertions check on every cycle that the pending index points at a set status bit with no set bit below it, that pendValid and cpuIrq agree with the status and mask contents, that the mask changes only through a mask write and then takes the written value, and that in the latched modes no status bit falls without a status write. The bench's scenarios are what show the mode-specific clear polarity, the two- and three-edge input latency, the single latch per rising edge while a line stays high, and the event winning over a clear in the same cycle. These come from a reference model that runs the three modes side by side on the same stimulus.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

  typedef enum logic [1:0] {
    IRQ_LIVE_LEVEL = 2'd0,
    IRQ_EDGE_W1C   = 2'd1,
    IRQ_LEVEL_W0C  = 2'd2
  } irqMode_e;

  // Strobes from the port decoder to the register datapath
  typedef struct packed {
    logic maskWr;
    logic statWr;
    logic rdEn;
    logic rdStat;
  } regStb_t;

endpackage

// File: rtl/irq_hub_ctrl.sv
module irq_hub_ctrl
  import irq_hub_pkg::*;
(
  input  logic    regSel,
  input  logic    regWr,
  input  logic    regAddr,
  output regStb_t stb
);

  always_comb begin
    stb.maskWr = regSel & regWr & ~regAddr;
    stb.statWr = regSel & regWr & regAddr;
    stb.rdEn   = regSel;
    stb.rdStat = regAddr;
  end

endmodule

// File: rtl/irq_hub_dpath.sv
module irq_hub_dpath
  import irq_hub_pkg::*;
#(
  parameter int       NUM_LINES = 32,
  parameter irqMode_e MODE      = IRQ_EDGE_W1C,
  localparam int      IDX_W     = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] srcIn,
  input  regStb_t              stb,
  input  logic [NUM_LINES-1:0] wdata,
  output logic [NUM_LINES-1:0] statusOut,
  output logic [NUM_LINES-1:0] maskOut,
  output logic [NUM_LINES-1:0] rdata,
  output logic                 cpuIrq,
  output logic [IDX_W-1:0]     pendIdx,
  output logic                 pendValid
);

  logic [NUM_LINES-1:0] syncA;
  logic [NUM_LINES-1:0] syncB;
  logic [NUM_LINES-1:0] maskQ;
  logic [NUM_LINES-1:0] statusVal;

  // Two-stage synchronizer on every source line
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= srcIn;
      syncB <= syncA;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           maskQ <= '0;
    else if (stb.maskWr) maskQ <= wdata;
  end

  generate
    if (MODE == IRQ_LIVE_LEVEL) begin : g_live
      logic unusedStatWr;
      assign unusedStatWr = stb.statWr;
      assign statusVal    = syncB;
    end else begin : g_latch
      logic [NUM_LINES-1:0] statusQ;
      logic [NUM_LINES-1:0] setVec;
      logic [NUM_LINES-1:0] clrVec;

      if (MODE == IRQ_EDGE_W1C) begin : g_edge
        logic [NUM_LINES-1:0] prevB;
        always_ff @(posedge clk) begin
          if (!rstN) prevB <= '0;
          else       prevB <= syncB;
        end
        assign setVec = syncB & ~prevB;
        assign clrVec = stb.statWr ? wdata : '0;
      end else begin : g_lvl
        assign setVec = syncB;
        assign clrVec = stb.statWr ? ~wdata : '0;
      end

      // Set has priority over a clear landing in the same cycle
      always_ff @(posedge clk) begin
        if (!rstN) statusQ <= '0;
        else       statusQ <= (statusQ & ~clrVec) | setVec;
      end
      assign statusVal = statusQ;
    end
  endgenerate

  // Lowest index wins: scan from the top so the last hit is the smallest
  always_comb begin
    pendIdx   = '0;
    pendValid = 1'b0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (statusVal[i]) begin
        pendIdx   = IDX_W'(i);
        pendValid = 1'b1;
      end
    end
  end

  always_comb begin
    if (!stb.rdEn)       rdata = '0;
    else if (stb.rdStat) rdata = statusVal;
    else                 rdata = maskQ;
  end

  assign cpuIrq    = |(statusVal & maskQ);
  assign statusOut = statusVal;
  assign maskOut   = maskQ;

endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int       NUM_LINES = 32,
  parameter irqMode_e MODE      = IRQ_EDGE_W1C,
  localparam int      IDX_W     = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] srcIn,
  input  logic                 regSel,
  input  logic                 regWr,
  input  logic                 regAddr,
  input  logic [NUM_LINES-1:0] regWdata,
  output logic [NUM_LINES-1:0] regRdata,
  output logic                 cpuIrq,
  output logic [IDX_W-1:0]     pendIdx,
  output logic                 pendValid
);

  regStb_t              stb;
  logic [NUM_LINES-1:0] statusBus;
  logic [NUM_LINES-1:0] maskBus;

  irq_hub_ctrl u_ctrl (
    .regSel  (regSel),
    .regWr   (regWr),
    .regAddr (regAddr),
    .stb     (stb)
  );

  irq_hub_dpath #(
    .NUM_LINES (NUM_LINES),
    .MODE      (MODE)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .srcIn     (srcIn),
    .stb       (stb),
    .wdata     (regWdata),
    .statusOut (statusBus),
    .maskOut   (maskBus),
    .rdata     (regRdata),
    .cpuIrq    (cpuIrq),
    .pendIdx   (pendIdx),
    .pendValid (pendValid)
  );

endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk
  import irq_hub_pkg::*;
#(
  parameter int       NUM_LINES = 32,
  parameter irqMode_e MODE      = IRQ_EDGE_W1C,
  localparam int      IDX_W     = $clog2(NUM_LINES)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 regSel,
  input logic                 regWr,
  input logic                 regAddr,
  input logic [NUM_LINES-1:0] regWdata,
  input logic [NUM_LINES-1:0] statusBus,
  input logic [NUM_LINES-1:0] maskBus,
  input logic                 cpuIrq,
  input logic [IDX_W-1:0]     pendIdx,
  input logic                 pendValid
);

  logic maskWrite;
  logic statWrite;
  logic [NUM_LINES-1:0] belowIdx;
  assign maskWrite = regSel && regWr && !regAddr;
  assign statWrite = regSel && regWr && regAddr;
  assign belowIdx  = (NUM_LINES'(1) << pendIdx) - NUM_LINES'(1);

  a_r10_idx_is_set: assert property (@(posedge clk) disable iff (!rstN)
    pendValid |-> statusBus[pendIdx]);

  a_r10_nothing_below: assert property (@(posedge clk) disable iff (!rstN)
    pendValid |-> ((statusBus & belowIdx) == '0));

  a_r10_valid_tracks: assert property (@(posedge clk) disable iff (!rstN)
    pendValid == (statusBus != '0));

  a_r9_irq_needs_pending: assert property (@(posedge clk) disable iff (!rstN)
    cpuIrq |-> pendValid);

  a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    cpuIrq |-> (maskBus != '0));

  a_r2_mask_takes_write: assert property (@(posedge clk) disable iff (!rstN)
    maskWrite |=> (maskBus == $past(regWdata)));

  a_r2_mask_holds: assert property (@(posedge clk) disable iff (!rstN)
    !maskWrite |=> $stable(maskBus));

  generate
    if (MODE != IRQ_LIVE_LEVEL) begin : g_latched
      // R5 / R6: a latched bit only falls through a status write
      a_r6_no_spontaneous_clear: assert property (@(posedge clk) disable iff (!rstN)
        !statWrite |=> ((statusBus & $past(statusBus)) == $past(statusBus)));
    end
  endgenerate

endmodule

bind irq_hub irq_hub_chk #(
  .NUM_LINES (NUM_LINES),
  .MODE      (MODE)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regSel    (regSel),
  .regWr     (regWr),
  .regAddr   (regAddr),
  .regWdata  (regWdata),
  .statusBus (statusBus),
  .maskBus   (maskBus),
  .cpuIrq    (cpuIrq),
  .pendIdx   (pendIdx),
  .pendValid (pendValid)
);

// File: tb/irq_hub_bench.sv
`timescale 1ns/1ps
module irq_hub_bench;
  import irq_hub_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] srcIn = '0;
  logic        regSel = 1'b0;
  logic        regWr = 1'b0;
  logic        regAddr = 1'b0;
  logic [31:0] regWdata = '0;

  // Index 0: live level, 1: edge W1C, 2: latched level W0C
  logic [31:0] rdA [3];
  logic        irqA [3];
  logic [4:0]  idxA [3];
  logic        valA [3];

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // Reference model state
  logic [31:0] hist [4];
  logic [31:0] mSt [3];
  logic [31:0] mMask;

  always #10 clk = ~clk;

  irq_hub #(.MODE(IRQ_LIVE_LEVEL)) u_irq_hub_lvl (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .regSel(regSel), .regWr(regWr),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(rdA[0]),
    .cpuIrq(irqA[0]), .pendIdx(idxA[0]), .pendValid(valA[0]));

  irq_hub #(.MODE(IRQ_EDGE_W1C)) u_irq_hub (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .regSel(regSel), .regWr(regWr),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(rdA[1]),
    .cpuIrq(irqA[1]), .pendIdx(idxA[1]), .pendValid(valA[1]));

  irq_hub #(.MODE(IRQ_LEVEL_W0C)) u_irq_hub_lat (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .regSel(regSel), .regWr(regWr),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(rdA[2]),
    .cpuIrq(irqA[2]), .pendIdx(idxA[2]), .pendValid(valA[2]));

  task automatic expectEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] lowestSet(input logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return {1'b1, 5'(i)};
    return 6'd0;
  endfunction

  task automatic modelReset();
    for (int i = 0; i < 4; i++) hist[i] = '0;
    for (int d = 0; d < 3; d++) mSt[d] = '0;
    mMask = '0;
  endtask

  // Advance the model across one clock edge using the inputs held at that edge
  task automatic modelEdge();
    logic [31:0] clr1, clr2;
    hist[3] = hist[2]; hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = srcIn;
    clr1 = (regSel && regWr && regAddr) ? regWdata  : '0;
    clr2 = (regSel && regWr && regAddr) ? ~regWdata : '0;
    mSt[0] = hist[1];
    mSt[1] = (mSt[1] & ~clr1) | (hist[2] & ~hist[3]);
    mSt[2] = (mSt[2] & ~clr2) | hist[2];
    if (regSel && regWr && !regAddr) mMask = regWdata;
  endtask

  task automatic compareAll();
    logic [5:0] low;
    logic [31:0] expRd;
    for (int d = 0; d < 3; d++) begin
      low   = lowestSet(mSt[d]);
      expRd = !regSel ? 32'h0 : (regAddr ? mSt[d] : mMask);
      expectEq($sformatf("R9 cpuIrq dut%0d", d), {31'b0, irqA[d]}, {31'b0, |(mSt[d] & mMask)});
      expectEq($sformatf("R10 pendValid dut%0d", d), {31'b0, valA[d]}, {31'b0, low[5]});
      expectEq($sformatf("R10 pendIdx dut%0d", d), {27'b0, idxA[d]}, {27'b0, low[4:0]});
      expectEq($sformatf("R2 R3 regRdata dut%0d", d), rdA[d], expRd);
    end
  endtask

  task automatic step(input logic [31:0] src, input logic sel, input logic wr,
                      input logic addr, input logic [31:0] wd);
    srcIn = src; regSel = sel; regWr = wr; regAddr = addr; regWdata = wd;
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    compareAll();
  endtask

  task automatic readStat(input logic [31:0] src);
    step(src, 1'b1, 1'b0, 1'b1, 32'h0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    // Reset state, read with the port selected
    regSel = 1'b1; regAddr = 1'b0; #1;
    for (int d = 0; d < 3; d++) expectEq("R2 mask reset", rdA[d], 32'h0);
    regAddr = 1'b1; #1;
    for (int d = 0; d < 3; d++) begin
      expectEq("R3 status reset", rdA[d], 32'h0);
      expectEq("R9 irq reset", {31'b0, irqA[d]}, 32'h0);
      expectEq("R10 valid reset", {31'b0, valA[d]}, 32'h0);
    end
    @(negedge clk);
    rstN = 1'b1;

    step(32'h0, 1'b1, 1'b1, 1'b0, 32'hFFFF_FFFF);    // enable every line

    // R4 latency: line 5 rises
    readStat(32'h20);
    readStat(32'h20);
    expectEq("R4 live two edges", rdA[0], 32'h20);
    expectEq("R4 edge not yet", rdA[1], 32'h0);
    readStat(32'h20);
    expectEq("R4 R5 edge three edges", rdA[1], 32'h20);
    expectEq("R4 R6 latched three edges", rdA[2], 32'h20);
    expectEq("R10 idx five", {27'b0, idxA[1]}, 32'd5);

    // Second line below it
    repeat (3) readStat(32'h24);
    expectEq("R10 idx two", {27'b0, idxA[1]}, 32'd2);
    expectEq("R5 edge two lines", rdA[1], 32'h24);

    // Write zero to status while lines still high
    step(32'h24, 1'b1, 1'b1, 1'b1, 32'h0);
    expectEq("R5 write0 no effect", rdA[1], 32'h24);
    expectEq("R8 latched level reasserts", rdA[2], 32'h24);
    expectEq("R7 live ignores write", rdA[0], 32'h24);

    // Inputs fall
    repeat (3) readStat(32'h0);
    expectEq("R5 edge holds", rdA[1], 32'h24);
    expectEq("R6 latched holds", rdA[2], 32'h24);
    expectEq("R7 live follows", rdA[0], 32'h0);

    step(32'h0, 1'b1, 1'b1, 1'b1, 32'h04);
    expectEq("R5 write1 clears bit2", rdA[1], 32'h20);
    expectEq("R6 write0 clears others", rdA[2], 32'h04);
    step(32'h0, 1'b1, 1'b1, 1'b1, 32'hFFFF_FFFF);
    expectEq("R5 write1 clears all", rdA[1], 32'h0);
    expectEq("R6 write1 no effect", rdA[2], 32'h04);
    expectEq("R10 empty valid low", {31'b0, valA[1]}, 32'h0);
    expectEq("R10 empty idx zero", {27'b0, idxA[1]}, 32'h0);
    step(32'h0, 1'b1, 1'b1, 1'b1, 32'h0);
    expectEq("R6 write0 clears bit2", rdA[2], 32'h0);

    // R8: rising edge lands in the same cycle as a clear of line 7
    readStat(32'h80);
    readStat(32'h80);
    step(32'h80, 1'b1, 1'b1, 1'b1, 32'h80);
    expectEq("R8 edge set beats clear", rdA[1], 32'h80);

    // R9 masking
    step(32'h80, 1'b1, 1'b1, 1'b0, 32'h0);
    expectEq("R9 masked no irq", {31'b0, irqA[1]}, 32'h0);
    expectEq("R10 masked still valid", {31'b0, valA[1]}, 32'h1);
    step(32'h80, 1'b1, 1'b1, 1'b0, 32'h80);
    expectEq("R9 unmasked irq", {31'b0, irqA[1]}, 32'h1);
    step(32'h80, 1'b0, 1'b0, 1'b1, 32'h0);
    expectEq("R2 deselected reads zero", rdA[1], 32'h0);

    // R1: top line
    repeat (3) readStat(32'h8000_0080);
    expectEq("R1 line31 latched", rdA[1], 32'h8000_0080);
    step(32'h8000_0080, 1'b1, 1'b1, 1'b1, 32'h80);
    expectEq("R5 held line no relatch", rdA[1], 32'h8000_0000);
    expectEq("R1 idx31", {27'b0, idxA[1]}, 32'd31);
    expectEq("R6 latched both", rdA[2], 32'h8000_0080);

    // Mixed pattern with random-ish stimulus, model compared every cycle
    for (int k = 0; k < 200; k++) begin
      logic [31:0] pat;
      pat = 32'h9E37_79B9 * (k + 1);
      step(pat ^ (pat >> 7), 1'b1, (k % 3) == 0, k[1], pat ^ 32'h5A5A_A5A5);
    end
    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finishRun();
  end

endmodule